// File: doc/BRIEF.md
# Capacitive Touch Detection Processor

This block turns a stream of 14-bit acquisition counts, one per measurement burst, into a debounced touch state. It keeps a reference level for the untouched key. It compares each new count against that reference using a fixed detect threshold and a smaller release margin. A consensus integrator must agree over several consecutive samples before the touch state changes in either direction. While no touch is in progress, the reference follows slow changes in the signal, and it follows falling signals faster than rising ones.

A maximum-on timer counts an external time tick while a touch is held. When it runs out, the block treats the detection as stuck and recalibrates. Software or a neighbouring block can also request a recalibration at any time. During calibration, the next valid sample becomes the new reference.

The controller has five named states:

- **CAL**: waiting for a sample to adopt as the reference.
- **IDLE**: no touch, drift tracking active.
- **ARM**: threshold crossed, integrating towards a touch.
- **HELD**: touch confirmed.
- **DROP**: release margin undercut, integrating towards release.

The transitions are:

- **load**: CAL to IDLE on any valid sample.
- **cross**: IDLE to ARM on a detecting sample.
- **confirm**: ARM to HELD on the fourth consecutive detecting sample.
- **abort**: ARM to IDLE on a non-detecting sample.
- **slip**: HELD to DROP on a sample below the release margin.
- **release**: DROP to IDLE on the fourth consecutive such sample.
- **recover**: DROP to HELD on a sample at or above the margin.
- **recal**: any state to CAL on a request or on timer expiry.

Top module: `tdp_touch_proc`

## Requirements
- R1: After reset `calibrating` is 1 and `touch_on` and `maybe_touch` are 0. The first valid sample becomes the reference, and `calibrating` is 0 from the next cycle.
- R2: A sample is detecting when it is at least the reference plus THR (10). A sample of reference plus 9 in IDLE leaves all outputs at 0.
- R3: The first detecting sample in IDLE raises `maybe_touch` in the following cycle. The DI_N-th (4th) consecutive detecting sample drops `maybe_touch` and raises `touch_on`. The two are never high together.
- R4: A non-detecting sample while integrating towards a touch returns the block to IDLE with the count cleared, so a full DI_N new detecting samples are needed.
- R5: While touched, DI_N consecutive samples below the reference plus THR minus HYS (8) clear `touch_on`. A sample at or above that level in between restarts the count.
- R6: While touched, samples at the reference plus 8 or 9 keep `touch_on` at 1 indefinitely.
- R7: In IDLE, each non-detecting sample above the reference advances an up counter, and each sample below it advances a down counter. The reference moves one count up after UP_RATE (16) such samples and one count down after DN_RATE (4) such samples. A move in the other direction or an equal sample clears the opposite counter or both counters. Outside IDLE the counters hold their values.
- R8: The reference does not change in ARM, HELD or DROP.
- R9: While a touch is held (HELD or DROP), `tick` pulses are counted. On the MAX_ON_TICKS-th (35th) pulse the block enters CAL in the next cycle, with `touch_on` cleared.
- R10: `recal_req` puts the block in CAL in the next cycle from any state, clearing detection and integration.
- R11: Without `smp_valid`, `recal_req` or `tick`, the outputs do not change, whatever is on `smp_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Qualifies `smp_value` for one cycle per burst |
| smp_value | input | 14 | Acquisition count |
| tick | input | 1 | Time-base pulse for the maximum-on timer |
| recal_req | input | 1 | Request for a full recalibration |
| touch_on | output | 1 | Confirmed touch |
| maybe_touch | output | 1 | Threshold crossed, touch not yet confirmed |
| calibrating | output | 1 | Waiting for a sample to become the reference |

## Verification
The assertions assume that `smp_valid`, `tick` and `recal_req` are single-cycle qualifiers sampled at the clock edge. They also assume that `smp_value` has meaning only when qualified. The bench drives every input at the falling edge and lowers each qualifier after one rising edge. It changes `smp_value` freely while `smp_valid` is low, so the property that idle cycles leave the outputs alone is exercised without breaking those assumptions. Every sample value stays well inside the 14-bit range, so the reference never reaches either rail during drift.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    typedef enum logic [2:0] {
        ST_CAL,
        ST_IDLE,
        ST_ARM,
        ST_HELD,
        ST_DROP
    } tdp_state_e;

endpackage

// File: rtl/tdp_cmp.sv
module tdp_cmp #(
    parameter int W   = 14,
    parameter int THR = 10,
    parameter int HYS = 2
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] ref_lvl,
    output logic         detect,
    output logic         keep,
    output logic         above,
    output logic         below
);
    localparam int DW = W + 2;
    localparam logic signed [DW-1:0] THR_S = DW'(THR);
    localparam logic signed [DW-1:0] KEEP_S = DW'(THR - HYS);

    logic signed [DW-1:0] delta;

    always_comb begin
        delta  = $signed({2'b00, sample}) - $signed({2'b00, ref_lvl});
        detect = (delta >= THR_S);
        keep   = (delta >= KEEP_S);
        above  = (sample > ref_lvl);
        below  = (sample < ref_lvl);
    end

endmodule

// File: rtl/tdp_ref_track.sv
module tdp_ref_track #(
    parameter int W       = 14,
    parameter int UP_RATE = 16,
    parameter int DN_RATE = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         step,
    input  logic         above,
    input  logic         below,
    input  logic [W-1:0] sample,
    output logic [W-1:0] ref_lvl
);
    localparam int UW = (UP_RATE < 2) ? 1 : $clog2(UP_RATE);
    localparam int NW = (DN_RATE < 2) ? 1 : $clog2(DN_RATE);
    localparam logic [UW-1:0] UP_LAST = UW'(UP_RATE - 1);
    localparam logic [NW-1:0] DN_LAST = NW'(DN_RATE - 1);

    logic [W-1:0]  ref_q;
    logic [UW-1:0] up_cnt;
    logic [NW-1:0] dn_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            up_cnt <= '0;
            dn_cnt <= '0;
        end else if (load) begin
            ref_q  <= sample;
            up_cnt <= '0;
            dn_cnt <= '0;
        end else if (clear) begin
            up_cnt <= '0;
            dn_cnt <= '0;
        end else if (step) begin
            if (above) begin
                dn_cnt <= '0;
                if (up_cnt == UP_LAST) begin
                    up_cnt <= '0;
                    ref_q  <= ref_q + 1'b1;
                end else begin
                    up_cnt <= up_cnt + 1'b1;
                end
            end else if (below) begin
                up_cnt <= '0;
                if (dn_cnt == DN_LAST) begin
                    dn_cnt <= '0;
                    ref_q  <= ref_q - 1'b1;
                end else begin
                    dn_cnt <= dn_cnt + 1'b1;
                end
            end else begin
                up_cnt <= '0;
                dn_cnt <= '0;
            end
        end
    end

    assign ref_lvl = ref_q;

endmodule

// File: rtl/tdp_on_timer.sv
module tdp_on_timer #(
    parameter int MAX_TICKS = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && tick && (cnt == LAST);

endmodule

// File: rtl/tdp_fsm.sv
module tdp_fsm
    import tdp_pkg::*;
#(
    parameter int DI_N = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic       detect,
    input  logic       keep,
    input  logic       force_cal,
    output tdp_state_e state,
    output logic       touch_on,
    output logic       maybe_touch,
    output logic       calibrating,
    output logic       load_ref,
    output logic       drift_step,
    output logic       timer_run
);
    localparam int DIW = $clog2(DI_N + 1);
    localparam logic [DIW-1:0] DI_LAST = DIW'(DI_N - 1);

    tdp_state_e   st_q, st_d;
    logic [DIW-1:0] di_q, di_d;

    always_comb begin
        st_d = st_q;
        di_d = di_q;
        if (force_cal) begin
            st_d = ST_CAL;
            di_d = '0;
        end else if (smp_valid) begin
            unique case (st_q)
                ST_CAL: begin
                    st_d = ST_IDLE;
                    di_d = '0;
                end
                ST_IDLE: begin
                    if (detect) begin
                        st_d = ST_ARM;
                        di_d = DIW'(1);
                    end
                end
                ST_ARM: begin
                    if (!detect) begin
                        st_d = ST_IDLE;
                        di_d = '0;
                    end else if (di_q == DI_LAST) begin
                        st_d = ST_HELD;
                        di_d = '0;
                    end else begin
                        di_d = di_q + 1'b1;
                    end
                end
                ST_HELD: begin
                    if (!keep) begin
                        st_d = ST_DROP;
                        di_d = DIW'(1);
                    end
                end
                ST_DROP: begin
                    if (keep) begin
                        st_d = ST_HELD;
                        di_d = '0;
                    end else if (di_q == DI_LAST) begin
                        st_d = ST_IDLE;
                        di_d = '0;
                    end else begin
                        di_d = di_q + 1'b1;
                    end
                end
                default: begin
                    st_d = ST_CAL;
                    di_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_CAL;
            di_q <= '0;
        end else begin
            st_q <= st_d;
            di_q <= di_d;
        end
    end

    always_comb begin
        touch_on    = 1'b0;
        maybe_touch = 1'b0;
        calibrating = 1'b0;
        timer_run   = 1'b0;
        load_ref    = 1'b0;
        drift_step  = 1'b0;
        unique case (st_q)
            ST_CAL: begin
                calibrating = 1'b1;
                load_ref    = smp_valid && !force_cal;
            end
            ST_IDLE: drift_step  = smp_valid && !force_cal && !detect;
            ST_ARM:  maybe_touch = 1'b1;
            ST_HELD, ST_DROP: begin
                touch_on  = 1'b1;
                timer_run = 1'b1;
            end
            default: calibrating = 1'b1;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/tdp_touch_proc.sv
module tdp_touch_proc
    import tdp_pkg::*;
#(
    parameter int W            = 14,
    parameter int THR          = 10,
    parameter int HYS          = 2,
    parameter int DI_N         = 4,
    parameter int UP_RATE      = 16,
    parameter int DN_RATE      = 4,
    parameter int MAX_ON_TICKS = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_value,
    input  logic         tick,
    input  logic         recal_req,
    output logic         touch_on,
    output logic         maybe_touch,
    output logic         calibrating
);
    tdp_state_e  state;
    logic [W-1:0] ref_lvl;
    logic detect, keep, above, below;
    logic load_ref, drift_step, timer_run, expire, force_cal;

    assign force_cal = recal_req || expire;

    tdp_cmp #(.W(W), .THR(THR), .HYS(HYS)) u_cmp (
        .sample (smp_value),
        .ref_lvl(ref_lvl),
        .detect (detect),
        .keep   (keep),
        .above  (above),
        .below  (below)
    );

    tdp_ref_track #(.W(W), .UP_RATE(UP_RATE), .DN_RATE(DN_RATE)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (calibrating),
        .load   (load_ref),
        .step   (drift_step),
        .above  (above),
        .below  (below),
        .sample (smp_value),
        .ref_lvl(ref_lvl)
    );

    tdp_on_timer #(.MAX_TICKS(MAX_ON_TICKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick),
        .expire(expire)
    );

    tdp_fsm #(.DI_N(DI_N)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .detect     (detect),
        .keep       (keep),
        .force_cal  (force_cal),
        .state      (state),
        .touch_on   (touch_on),
        .maybe_touch(maybe_touch),
        .calibrating(calibrating),
        .load_ref   (load_ref),
        .drift_step (drift_step),
        .timer_run  (timer_run)
    );

endmodule

// File: rtl/tdp_touch_chk.sv
module tdp_touch_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_valid,
    input logic         tick,
    input logic         recal_req,
    input logic         touch_on,
    input logic         maybe_touch,
    input logic         calibrating,
    input logic [W-1:0] ref_lvl
);
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(touch_on && maybe_touch));

    p_rise_from_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(touch_on) |-> $past(maybe_touch));

    p_cal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        calibrating |-> (!touch_on && !maybe_touch));

    p_recal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        recal_req |=> calibrating);

    p_frozen_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_on || maybe_touch) |=> $stable(ref_lvl));

    p_release_on_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(touch_on) && !calibrating) |-> $past(smp_valid));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !tick && !recal_req) |=>
            $stable({touch_on, maybe_touch, calibrating}));

endmodule

bind tdp_touch_proc tdp_touch_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .tick       (tick),
    .recal_req  (recal_req),
    .touch_on   (touch_on),
    .maybe_touch(maybe_touch),
    .calibrating(calibrating),
    .ref_lvl    (ref_lvl)
);

// File: tb/tb_tdp_touch_proc.sv
module tb_tdp_touch_proc;
    localparam int W = 14;
    localparam int THR = 10;
    localparam int HYS = 2;
    localparam int DI_N = 4;
    localparam int UP_RATE = 16;
    localparam int DN_RATE = 4;
    localparam int MAXON = 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [W-1:0] smp_value = '0;
    logic tick = 1'b0;
    logic recal_req = 1'b0;
    logic touch_on, maybe_touch, calibrating;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    tdp_touch_proc dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_value(smp_value),
        .tick(tick), .recal_req(recal_req), .touch_on(touch_on),
        .maybe_touch(maybe_touch), .calibrating(calibrating)
    );

    // Behavioural reference model: 0 cal, 1 idle, 2 arm, 3 held, 4 drop
    int m_st = 0, m_ref = 0, m_di = 0, m_up = 0, m_dn = 0, m_on = 0;

    always @(posedge clk) begin
        int d;
        bit exp_now;
        if (!rst_n) begin
            m_st = 0; m_ref = 0; m_di = 0; m_up = 0; m_dn = 0; m_on = 0;
        end else begin
            exp_now = (m_st >= 3) && tick && (m_on == MAXON - 1);
            if (m_st >= 3) begin
                if (tick) m_on++;
            end else m_on = 0;
            if (recal_req || exp_now) begin
                m_st = 0; m_di = 0; m_up = 0; m_dn = 0;
            end else if (smp_valid) begin
                d = int'(smp_value) - m_ref;
                case (m_st)
                    0: begin m_ref = int'(smp_value); m_up = 0; m_dn = 0; m_st = 1; end
                    1: if (d >= THR) begin m_st = 2; m_di = 1; end
                       else if (d > 0) begin
                           m_dn = 0; m_up++;
                           if (m_up == UP_RATE) begin m_up = 0; m_ref++; end
                       end else if (d < 0) begin
                           m_up = 0; m_dn++;
                           if (m_dn == DN_RATE) begin m_dn = 0; m_ref--; end
                       end else begin m_up = 0; m_dn = 0; end
                    2: if (d < THR) begin m_st = 1; m_di = 0; end
                       else begin m_di++; if (m_di == DI_N) begin m_st = 3; m_di = 0; end end
                    3: if (d < THR - HYS) begin m_st = 4; m_di = 1; end
                    default: if (d >= THR - HYS) begin m_st = 3; m_di = 0; end
                       else begin m_di++; if (m_di == DI_N) begin m_st = 1; m_di = 0; end end
                endcase
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            total++;
            if (touch_on !== (m_st >= 3) || maybe_touch !== (m_st == 2) ||
                calibrating !== (m_st == 0)) begin
                bad++;
                $display("FAIL %s: t/m/c=%b%b%b expected %b%b%b", cur_req,
                         touch_on, maybe_touch, calibrating,
                         m_st >= 3, m_st == 2, m_st == 0);
            end
        end
    end

    task automatic expect3(string tag, bit t, bit m, bit c);
        total++;
        if (touch_on !== t || maybe_touch !== m || calibrating !== c) begin
            bad++;
            $display("FAIL %s: t/m/c=%b%b%b expected %b%b%b", tag,
                     touch_on, maybe_touch, calibrating, t, m, c);
        end
    endtask

    task automatic send(int v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_value = W'(v);
        @(posedge clk);
        #1;
        smp_valid = 1'b0;
    endtask

    task automatic send_n(int v, int n);
        for (int i = 0; i < n; i++) send(v);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic pulse_recal();
        @(negedge clk);
        recal_req = 1'b1;
        @(posedge clk);
        #1;
        recal_req = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        cur_req = "R1";
        expect3("R1", 0, 0, 1);
        send(1000);
        expect3("R1", 0, 0, 0);

        cur_req = "R2";
        send(1009);
        expect3("R2", 0, 0, 0);
        send(1010);
        expect3("R2", 0, 1, 0);

        cur_req = "R3";
        send_n(1010, 2);
        expect3("R3", 0, 1, 0);
        send(1010);
        expect3("R3", 1, 0, 0);

        cur_req = "R6";
        send_n(1008, 3);
        send_n(1009, 3);
        expect3("R6", 1, 0, 0);

        cur_req = "R5";
        send_n(1007, 3);
        expect3("R5", 1, 0, 0);
        send(1020);
        send_n(1007, 3);
        expect3("R5", 1, 0, 0);
        send(1007);
        expect3("R5", 0, 0, 0);

        cur_req = "R4";
        send(1000);
        send_n(1015, 3);
        expect3("R4", 0, 1, 0);
        send(1000);
        expect3("R4", 0, 0, 0);
        send_n(1015, 3);
        expect3("R4", 0, 1, 0);
        send(1000);
        expect3("R4", 0, 0, 0);

        cur_req = "R7";
        send_n(1005, 2 * UP_RATE);
        send(1011);
        expect3("R7", 0, 0, 0);
        send_n(900, 2 * DN_RATE);
        send(1010);
        expect3("R7", 0, 1, 0);
        send(1000);

        cur_req = "R11";
        @(negedge clk);
        smp_value = W'(5000);
        repeat (3) @(posedge clk);
        #1;
        expect3("R11", 0, 0, 0);
        send(1000);

        cur_req = "R8";
        send_n(1010, DI_N);
        expect3("R8", 1, 0, 0);
        send_n(1009, 40);
        send_n(1000, DI_N);
        expect3("R8", 0, 0, 0);
        send(1010);
        expect3("R8", 0, 1, 0);
        send(1000);

        cur_req = "R9";
        send_n(1010, DI_N);
        for (int i = 0; i < MAXON - 1; i++) pulse_tick();
        expect3("R9", 1, 0, 0);
        pulse_tick();
        expect3("R9", 0, 0, 1);
        send(1000);
        expect3("R9", 0, 0, 0);

        cur_req = "R10";
        send_n(1010, 2);
        expect3("R10", 0, 1, 0);
        pulse_recal();
        expect3("R10", 0, 0, 1);
        send(1000);
        send_n(1010, DI_N);
        pulse_recal();
        expect3("R10", 0, 0, 1);
        send(1000);
        expect3("R10", 0, 0, 0);

        repeat (4) @(posedge clk);
        #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule